// File: doc/BRIEF.md
# Decode-Time Branch Target Checker

This block sits in the decode stage and audits the branch prediction attached to every instruction token in a bundle. Each slot of the bundle carries a valid bit, a thread number, a sequence number, the instruction PC, the predicted next PC, a predicted-taken bit, the control, direct and unconditional class flags, and the branch target computed earlier in decode. The checker registers the bundle one cycle later on its output side. Every slot is forwarded in the slot it arrived in, with its prediction corrected and a squash mark where needed.

Two kinds of wrong guess are caught. A direct unconditional branch whose computed target disagrees with its predicted next PC is one kind. An instruction that was predicted taken but is not a control transfer is the other. When either is seen, the checker picks the oldest offender in the bundle and sends fetch a redirect record naming that instruction, the correct next PC and the direction. It then squashes the younger tokens of the same thread in the same bundle. A running count of resolved direct unconditional branches is kept beside the record.

Top module: `decode_branch_checker`

## Requirements
- R1: While reset is held and on the first cycle after it, every output is zero: no valid slots, no squash marks, no redirect, and a resolved count of zero.
- R2: A valid input slot appears on the output one clock later, in the same slot position. It has outValid set and outSquashed clear when the bundle has no offender.
- R3: A valid slot with the control, direct and unconditional flags all set is a checked branch. If its computed target differs from its predicted next PC, then one clock later redirValid, redirMispred and redirPredWrong are all 1. The record also carries redirSeq and redirTid of that slot, and redirNextPc equals its computed target.
- R4: A valid slot with predicted-taken set and the control flag clear is an offender. It produces the same redirect, with redirNextPc equal to its computed target, whatever its other flags are.
- R5: A control slot that is conditional or indirect never causes a redirect because of a target mismatch.
- R6: redirTaken is 1 exactly when the offender's predicted next PC differs from its PC plus INST_BYTES (4 by default), compared at ADDR_W bits.
- R7: When a redirect fires, a valid slot is marked outSquashed exactly when it has the offender's thread number and a sequence number that is greater as an unsigned SEQ_W-bit value. Older slots and slots of other threads stay unsquashed.
- R8: The offending slot itself is forwarded with outValid set and outSquashed clear.
- R9: When several slots offend in one bundle, only the one with the smallest sequence number produces the redirect. An offender younger than it in the same thread is squashed.
- R10: For every valid checked branch, outPredTarg carries the computed target. For every other valid slot, it carries the predicted next PC unchanged.
- R11: resolvedCount grows, one clock after the bundle, by the number of valid checked branches that are not squashed. It wraps at CNT_W bits.
- R12: A slot with its valid bit clear has no effect: it is output with outValid clear, it never offends and it is never counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | WIDTH | Slot holds an instruction |
| inTid | input | WIDTH*TID_W | Thread number per slot |
| inSeq | input | WIDTH*SEQ_W | Sequence number per slot |
| inPc | input | WIDTH*ADDR_W | Instruction PC per slot |
| inNextPc | input | WIDTH*ADDR_W | Predicted next PC per slot |
| inTarget | input | WIDTH*ADDR_W | Computed branch target per slot |
| inPredTaken | input | WIDTH | Predictor said taken |
| inIsCtrl | input | WIDTH | Instruction is a control transfer |
| inIsDirect | input | WIDTH | Target is PC-relative or absolute immediate |
| inIsUncond | input | WIDTH | Control transfer is unconditional |
| outValid | output | WIDTH | Forwarded slot valid |
| outSquashed | output | WIDTH | Forwarded slot is squashed |
| outPredTarg | output | WIDTH*ADDR_W | Corrected predicted target per slot |
| redirValid | output | 1 | Redirect record valid (squash request) |
| redirMispred | output | 1 | Record marks a branch misprediction |
| redirPredWrong | output | 1 | Record marks the prediction incorrect |
| redirTid | output | TID_W | Thread of the offender |
| redirSeq | output | SEQ_W | Sequence number of the offender |
| redirNextPc | output | ADDR_W | Correct next PC for fetch |
| redirTaken | output | 1 | Offender's next PC is not the fall-through |
| resolvedCount | output | CNT_W | Running count of resolved direct unconditional branches |

## Verification
The bench targets bundles where the oldest offender is not in the lowest slot. A design that picked by slot position would redirect to the wrong sequence number and squash an older instruction. It mixes threads and older slots around an offender, which exposes a squash mask that ignores thread number or compares with greater-or-equal and so kills the offender itself. Conditional and indirect branches with mismatched targets, and invalid slots that carry offending flags, catch a checker that fires too widely. Fall-through and non-fall-through predictions catch a wrong taken bit or a wrong instruction size.

// File: rtl/brchk_pkg.sv
package brchk_pkg;
  // Widest slot index the strobe struct can carry (up to 16 slots).
  localparam int SLOT_IDX_W = 4;

  // Strobes from the selection control to the datapath.
  typedef struct packed {
    logic                  fire;    // an offender exists this cycle
    logic [SLOT_IDX_W-1:0] offIdx;  // slot of the oldest offender
  } chkStrobe_t;
endpackage

// File: rtl/brchk_control.sv
module brchk_control
  import brchk_pkg::*;
#(
  parameter int WIDTH = 4,
  parameter int SEQ_W = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [WIDTH-1:0]       slotBad,
  input  logic [WIDTH*SEQ_W-1:0] inSeq,
  output chkStrobe_t             strobes
);
  logic [SEQ_W-1:0] bestSeq;

  // Oldest offender: smallest unsigned sequence number, lowest slot on a tie.
  always_comb begin
    strobes = '0;
    bestSeq = '0;
    for (int j = 0; j < WIDTH; j++) begin
      if (slotBad[j] && (!strobes.fire || inSeq[j*SEQ_W +: SEQ_W] < bestSeq)) begin
        strobes.fire   = 1'b1;
        strobes.offIdx = SLOT_IDX_W'(j);
        bestSeq        = inSeq[j*SEQ_W +: SEQ_W];
      end
    end
  end

  // R9: the chosen slot must really be offending.
  assert_pick_is_bad_R9: assert property (@(posedge clk) disable iff (rst)
    strobes.fire |-> slotBad[strobes.offIdx]);

  // R3: any offending slot forces a redirect.
  assert_bad_fires_R3: assert property (@(posedge clk) disable iff (rst)
    (|slotBad) |-> strobes.fire);
endmodule

// File: rtl/brchk_datapath.sv
module brchk_datapath
  import brchk_pkg::*;
#(
  parameter int WIDTH      = 4,
  parameter int TID_W      = 1,
  parameter int SEQ_W      = 16,
  parameter int ADDR_W     = 32,
  parameter int INST_BYTES = 4,
  parameter int CNT_W      = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [WIDTH-1:0]        inValid,
  input  logic [WIDTH*TID_W-1:0]  inTid,
  input  logic [WIDTH*SEQ_W-1:0]  inSeq,
  input  logic [WIDTH*ADDR_W-1:0] inPc,
  input  logic [WIDTH*ADDR_W-1:0] inNextPc,
  input  logic [WIDTH*ADDR_W-1:0] inTarget,
  input  logic [WIDTH-1:0]        inPredTaken,
  input  logic [WIDTH-1:0]        inIsCtrl,
  input  logic [WIDTH-1:0]        inIsDirect,
  input  logic [WIDTH-1:0]        inIsUncond,
  input  chkStrobe_t              strobes,
  output logic [WIDTH-1:0]        slotBad,
  output logic [WIDTH-1:0]        outValid,
  output logic [WIDTH-1:0]        outSquashed,
  output logic [WIDTH*ADDR_W-1:0] outPredTarg,
  output logic                    redirValid,
  output logic                    redirMispred,
  output logic                    redirPredWrong,
  output logic [TID_W-1:0]        redirTid,
  output logic [SEQ_W-1:0]        redirSeq,
  output logic [ADDR_W-1:0]       redirNextPc,
  output logic                    redirTaken,
  output logic [CNT_W-1:0]        resolvedCount
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(INST_BYTES);

  logic [WIDTH-1:0]        checked;
  logic [WIDTH-1:0]        kill;
  logic [WIDTH*ADDR_W-1:0] fixedTarg;
  logic [TID_W-1:0]        offTid;
  logic [SEQ_W-1:0]        offSeq;
  logic [ADDR_W-1:0]       offPc, offNextPc, offTarget;
  logic [CNT_W-1:0]        countInc;
  logic [SLOT_IDX_W-1:0]   offIdxQ;

  // Per-slot classification and target correction.
  for (genvar j = 0; j < WIDTH; j++) begin : gSlot
    logic tgtBad, ctrlBad;
    assign checked[j] = inValid[j] & inIsCtrl[j] & inIsDirect[j] & inIsUncond[j];
    assign tgtBad     = checked[j] &
                        (inTarget[j*ADDR_W +: ADDR_W] != inNextPc[j*ADDR_W +: ADDR_W]);
    assign ctrlBad    = inValid[j] & inPredTaken[j] & ~inIsCtrl[j];
    assign slotBad[j] = tgtBad | ctrlBad;
    assign fixedTarg[j*ADDR_W +: ADDR_W] = checked[j] ? inTarget[j*ADDR_W +: ADDR_W]
                                                      : inNextPc[j*ADDR_W +: ADDR_W];
  end

  // Fields of the selected offender.
  always_comb begin
    offTid    = '0;
    offSeq    = '0;
    offPc     = '0;
    offNextPc = '0;
    offTarget = '0;
    for (int j = 0; j < WIDTH; j++) begin
      if (int'(strobes.offIdx) == j) begin
        offTid    = inTid[j*TID_W +: TID_W];
        offSeq    = inSeq[j*SEQ_W +: SEQ_W];
        offPc     = inPc[j*ADDR_W +: ADDR_W];
        offNextPc = inNextPc[j*ADDR_W +: ADDR_W];
        offTarget = inTarget[j*ADDR_W +: ADDR_W];
      end
    end
  end

  // Selective squash of younger same-thread tokens and resolved count.
  always_comb begin
    kill     = '0;
    countInc = '0;
    for (int j = 0; j < WIDTH; j++) begin
      kill[j] = strobes.fire & inValid[j] &
                (inTid[j*TID_W +: TID_W] == offTid) &
                (inSeq[j*SEQ_W +: SEQ_W] > offSeq);
      if (checked[j] && !kill[j]) countInc = countInc + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      outValid       <= '0;
      outSquashed    <= '0;
      outPredTarg    <= '0;
      redirValid     <= 1'b0;
      redirMispred   <= 1'b0;
      redirPredWrong <= 1'b0;
      redirTid       <= '0;
      redirSeq       <= '0;
      redirNextPc    <= '0;
      redirTaken     <= 1'b0;
      resolvedCount  <= '0;
      offIdxQ        <= '0;
    end else begin
      outValid       <= inValid;
      outSquashed    <= kill;
      outPredTarg    <= fixedTarg;
      redirValid     <= strobes.fire;
      redirMispred   <= strobes.fire;
      redirPredWrong <= strobes.fire;
      redirTid       <= strobes.fire ? offTid : '0;
      redirSeq       <= strobes.fire ? offSeq : '0;
      redirNextPc    <= strobes.fire ? offTarget : '0;
      redirTaken     <= strobes.fire & (offNextPc != offPc + STEP);
      resolvedCount  <= resolvedCount + countInc;
      offIdxQ        <= strobes.offIdx;
    end
  end

  // R7: a squash mark only ever sits on a forwarded valid slot.
  assert_squash_on_valid_R7: assert property (@(posedge clk) disable iff (rst)
    (outSquashed & ~outValid) == '0);

  // R8: the offender leaves valid and unsquashed.
  assert_offender_kept_R8: assert property (@(posedge clk) disable iff (rst)
    redirValid |-> (outValid[offIdxQ] && !outSquashed[offIdxQ]));

  // R12: a redirect needs at least one valid slot in the previous bundle.
  assert_redirect_needs_input_R12: assert property (@(posedge clk) disable iff (rst)
    redirValid |-> $past(|inValid));

  // R11: the count never steps by more than a full bundle.
  assert_count_step_R11: assert property (@(posedge clk) disable iff (rst)
    CNT_W'(resolvedCount - $past(resolvedCount)) <= CNT_W'(WIDTH));
endmodule

// File: rtl/decode_branch_checker.sv
module decode_branch_checker
  import brchk_pkg::*;
#(
  parameter int WIDTH      = 4,   // slots per bundle, at most 16
  parameter int TID_W      = 1,
  parameter int SEQ_W      = 16,
  parameter int ADDR_W     = 32,
  parameter int INST_BYTES = 4,
  parameter int CNT_W      = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [WIDTH-1:0]        inValid,
  input  logic [WIDTH*TID_W-1:0]  inTid,
  input  logic [WIDTH*SEQ_W-1:0]  inSeq,
  input  logic [WIDTH*ADDR_W-1:0] inPc,
  input  logic [WIDTH*ADDR_W-1:0] inNextPc,
  input  logic [WIDTH*ADDR_W-1:0] inTarget,
  input  logic [WIDTH-1:0]        inPredTaken,
  input  logic [WIDTH-1:0]        inIsCtrl,
  input  logic [WIDTH-1:0]        inIsDirect,
  input  logic [WIDTH-1:0]        inIsUncond,
  output logic [WIDTH-1:0]        outValid,
  output logic [WIDTH-1:0]        outSquashed,
  output logic [WIDTH*ADDR_W-1:0] outPredTarg,
  output logic                    redirValid,
  output logic                    redirMispred,
  output logic                    redirPredWrong,
  output logic [TID_W-1:0]        redirTid,
  output logic [SEQ_W-1:0]        redirSeq,
  output logic [ADDR_W-1:0]       redirNextPc,
  output logic                    redirTaken,
  output logic [CNT_W-1:0]        resolvedCount
);
  chkStrobe_t       strobes;
  logic [WIDTH-1:0] slotBad;

  brchk_control #(.WIDTH(WIDTH), .SEQ_W(SEQ_W)) u_control (
    .clk(clk), .rst(rst), .slotBad(slotBad), .inSeq(inSeq), .strobes(strobes)
  );

  brchk_datapath #(
    .WIDTH(WIDTH), .TID_W(TID_W), .SEQ_W(SEQ_W), .ADDR_W(ADDR_W),
    .INST_BYTES(INST_BYTES), .CNT_W(CNT_W)
  ) u_datapath (
    .clk(clk), .rst(rst),
    .inValid(inValid), .inTid(inTid), .inSeq(inSeq), .inPc(inPc),
    .inNextPc(inNextPc), .inTarget(inTarget), .inPredTaken(inPredTaken),
    .inIsCtrl(inIsCtrl), .inIsDirect(inIsDirect), .inIsUncond(inIsUncond),
    .strobes(strobes), .slotBad(slotBad),
    .outValid(outValid), .outSquashed(outSquashed), .outPredTarg(outPredTarg),
    .redirValid(redirValid), .redirMispred(redirMispred),
    .redirPredWrong(redirPredWrong), .redirTid(redirTid), .redirSeq(redirSeq),
    .redirNextPc(redirNextPc), .redirTaken(redirTaken),
    .resolvedCount(resolvedCount)
  );
endmodule

// File: tb/decode_branch_checker_bench.sv
module decode_branch_checker_bench;
  localparam int W = 4, TW = 1, SW = 16, AW = 32, CW = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;   // 50 MHz

  logic [W-1:0]    inValid, inPredTaken, inIsCtrl, inIsDirect, inIsUncond;
  logic [W*TW-1:0] inTid;
  logic [W*SW-1:0] inSeq;
  logic [W*AW-1:0] inPc, inNextPc, inTarget;
  logic [W-1:0]    outValid, outSquashed;
  logic [W*AW-1:0] outPredTarg;
  logic            redirValid, redirMispred, redirPredWrong, redirTaken;
  logic [TW-1:0]   redirTid;
  logic [SW-1:0]   redirSeq;
  logic [AW-1:0]   redirNextPc;
  logic [CW-1:0]   resolvedCount;

  decode_branch_checker u_decode_branch_checker (
    .clk(clk), .rst(rst), .inValid(inValid), .inTid(inTid), .inSeq(inSeq),
    .inPc(inPc), .inNextPc(inNextPc), .inTarget(inTarget),
    .inPredTaken(inPredTaken), .inIsCtrl(inIsCtrl), .inIsDirect(inIsDirect),
    .inIsUncond(inIsUncond), .outValid(outValid), .outSquashed(outSquashed),
    .outPredTarg(outPredTarg), .redirValid(redirValid),
    .redirMispred(redirMispred), .redirPredWrong(redirPredWrong),
    .redirTid(redirTid), .redirSeq(redirSeq), .redirNextPc(redirNextPc),
    .redirTaken(redirTaken), .resolvedCount(resolvedCount)
  );

  // Stimulus slots.
  int unsigned sV[W], sTid[W], sSeq[W], sPc[W], sNp[W], sTg[W];
  int unsigned sPt[W], sC[W], sD[W], sU[W];

  // Reference expectations for the next output cycle.
  int unsigned eV[W], eSq[W], ePt[W];
  int unsigned eRv, eTid, eSeq, eNext, eTaken;
  int unsigned eCnt = 0;

  int checks = 0, errors = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clearSlots();
    for (int j = 0; j < W; j++) begin
      sV[j] = 0; sTid[j] = 0; sSeq[j] = j; sPc[j] = 32'h100 + 4*j;
      sNp[j] = sPc[j] + 4; sTg[j] = sPc[j] + 4;
      sPt[j] = 0; sC[j] = 0; sD[j] = 0; sU[j] = 0;
    end
  endtask

  task automatic setSlot(input int j, input int unsigned tid, input int unsigned seq,
                         input int unsigned pc, input int unsigned np, input int unsigned tg,
                         input int unsigned pt, input int unsigned c, input int unsigned d,
                         input int unsigned u);
    sV[j] = 1; sTid[j] = tid; sSeq[j] = seq; sPc[j] = pc; sNp[j] = np; sTg[j] = tg;
    sPt[j] = pt; sC[j] = c; sD[j] = d; sU[j] = u;
  endtask

  // Drive the current slots and build the expectation from the requirements.
  task automatic applySlots();
    int off;
    off = -1;
    for (int j = 0; j < W; j++) begin
      inValid[j]     = sV[j][0];
      inPredTaken[j] = sPt[j][0];
      inIsCtrl[j]    = sC[j][0];
      inIsDirect[j]  = sD[j][0];
      inIsUncond[j]  = sU[j][0];
      inTid[j*TW +: TW]  = sTid[j][TW-1:0];
      inSeq[j*SW +: SW]  = sSeq[j][SW-1:0];
      inPc[j*AW +: AW]     = sPc[j];
      inNextPc[j*AW +: AW] = sNp[j];
      inTarget[j*AW +: AW] = sTg[j];
    end
    // R3/R4/R9/R12: oldest valid offender.
    for (int j = 0; j < W; j++) begin
      bit bad;
      bad = sV[j] != 0 && ((sPt[j] != 0 && sC[j] == 0) ||
            (sC[j] != 0 && sD[j] != 0 && sU[j] != 0 && sTg[j] != sNp[j]));
      if (bad && (off < 0 || sSeq[j] < sSeq[off])) off = j;
    end
    eRv = (off >= 0);
    eTid = 0; eSeq = 0; eNext = 0; eTaken = 0;
    if (off >= 0) begin
      eTid = sTid[off]; eSeq = sSeq[off]; eNext = sTg[off];
      eTaken = (sNp[off] != sPc[off] + 4);
    end
    for (int j = 0; j < W; j++) begin
      bit isChk;
      isChk  = sV[j] != 0 && sC[j] != 0 && sD[j] != 0 && sU[j] != 0;
      eV[j]  = sV[j];
      eSq[j] = (off >= 0 && sV[j] != 0 && sTid[j] == sTid[off] && sSeq[j] > sSeq[off]);
      ePt[j] = isChk ? sTg[j] : sNp[j];
      if (isChk && eSq[j] == 0) eCnt = (eCnt + 1) & 32'hFFFF;
    end
  endtask

  task automatic checkOutputs(input string ctx);
    for (int j = 0; j < W; j++) begin
      chk(outValid[j] == eV[j][0], {ctx, " R2/R12 outValid"}, outValid[j], eV[j]);
      chk(outSquashed[j] == eSq[j][0], {ctx, " R7/R8 outSquashed"}, outSquashed[j], eSq[j]);
      if (eV[j] != 0)
        chk(outPredTarg[j*AW +: AW] == ePt[j], {ctx, " R10 outPredTarg"},
            outPredTarg[j*AW +: AW], ePt[j]);
    end
    chk(redirValid == eRv[0], {ctx, " R3/R4/R5 redirValid"}, redirValid, eRv);
    if (eRv != 0) begin
      chk(redirMispred && redirPredWrong, {ctx, " R3 record flags"},
          {redirMispred, redirPredWrong}, 2'b11);
      chk(redirSeq == eSeq[SW-1:0], {ctx, " R9 redirSeq"}, redirSeq, eSeq);
      chk(redirTid == eTid[TW-1:0], {ctx, " R3 redirTid"}, redirTid, eTid);
      chk(redirNextPc == eNext, {ctx, " R3 redirNextPc"}, redirNextPc, eNext);
      chk(redirTaken == eTaken[0], {ctx, " R6 redirTaken"}, redirTaken, eTaken);
    end
    chk(resolvedCount == eCnt[CW-1:0], {ctx, " R11 resolvedCount"}, resolvedCount, eCnt);
  endtask

  // Drive at a falling edge, let one rising edge register it, check at the next fall.
  task automatic step(input string ctx);
    applySlots();
    @(negedge clk);
    checkOutputs(ctx);
  endtask

  initial begin
    clearSlots();
    applySlots();
    eCnt = 0;
    repeat (3) @(negedge clk);
    // R1: reset state.
    chk(outValid == '0 && outSquashed == '0 && !redirValid && !redirMispred &&
        !redirPredWrong && resolvedCount == '0, "R1 reset state", outValid, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(outValid == '0 && !redirValid && resolvedCount == '0, "R1 after reset", outValid, 0);

    // R2/R10: clean bundle with one correct checked branch.
    clearSlots();
    setSlot(0, 0, 10, 32'h1000, 32'h1004, 32'h1004, 0, 0, 0, 0);
    setSlot(1, 0, 11, 32'h1004, 32'h2000, 32'h2000, 1, 1, 1, 1);
    setSlot(2, 0, 12, 32'h2000, 32'h2004, 32'h2004, 0, 0, 0, 0);
    setSlot(3, 0, 13, 32'h2004, 32'h2008, 32'h2008, 0, 0, 0, 0);
    step("clean");

    // R3/R7/R8/R6: target mismatch in slot 1, older slot 0 survives.
    clearSlots();
    setSlot(0, 0, 20, 32'h3000, 32'h3004, 32'h3004, 0, 0, 0, 0);
    setSlot(1, 0, 21, 32'h3004, 32'h3008, 32'h4000, 0, 1, 1, 1);
    setSlot(2, 0, 22, 32'h3008, 32'h300C, 32'h300C, 0, 0, 0, 0);
    setSlot(3, 0, 23, 32'h300C, 32'h5000, 32'h5000, 1, 1, 1, 1);
    step("target mismatch");

    // R4/R6: false control predicted taken, fall-through next PC (taken bit 0).
    clearSlots();
    setSlot(0, 1, 30, 32'h6000, 32'h6004, 32'h6004, 1, 0, 0, 0);
    setSlot(1, 1, 31, 32'h6004, 32'h6008, 32'h6008, 0, 0, 0, 0);
    setSlot(2, 0, 32, 32'h6008, 32'h600C, 32'h600C, 0, 0, 0, 0);
    step("false control");

    // R5: conditional direct and indirect unconditional with wrong targets.
    clearSlots();
    setSlot(0, 0, 40, 32'h7000, 32'h7100, 32'h7200, 1, 1, 1, 0);
    setSlot(1, 0, 41, 32'h7100, 32'h7300, 32'h7400, 1, 1, 0, 1);
    step("not checked");

    // R9/R7: two offenders, the older sits in the higher slot; other thread kept.
    clearSlots();
    setSlot(0, 0, 55, 32'h8000, 32'h8800, 32'h8900, 1, 1, 1, 1);
    setSlot(1, 1, 56, 32'h8004, 32'h8008, 32'h8008, 0, 0, 0, 0);
    setSlot(2, 0, 51, 32'h8100, 32'h8104, 32'h8104, 1, 0, 0, 0);
    setSlot(3, 0, 50, 32'h8200, 32'h8204, 32'h8204, 0, 0, 0, 0);
    step("oldest offender");

    // R12: invalid slot carrying offending fields.
    clearSlots();
    sPt[0] = 1; sC[0] = 0; sSeq[0] = 3;
    sC[1] = 1; sD[1] = 1; sU[1] = 1; sTg[1] = 32'hDEAD0;
    setSlot(2, 0, 70, 32'h9000, 32'h9004, 32'h9004, 0, 0, 0, 0);
    step("invalid slots");

    // Mixed bundles with varied ages, threads and predictions.
    for (int n = 0; n < 400; n++) begin
      int unsigned base, rot;
      base = $urandom_range(0, 60000);
      rot  = $urandom_range(0, 3);
      clearSlots();
      for (int j = 0; j < W; j++) begin
        int unsigned pc;
        pc = $urandom_range(0, 32'h3FFF) * 4;
        sV[j]   = ($urandom_range(0, 7) != 0);
        sTid[j] = $urandom_range(0, 1);
        sSeq[j] = base + ((j * 3 + rot) % W) * 2;
        sPc[j]  = pc;
        sNp[j]  = $urandom_range(0, 1) ? pc + 4 : pc + $urandom_range(1, 64) * 4;
        sTg[j]  = $urandom_range(0, 2) != 0 ? sNp[j] : pc + $urandom_range(1, 64) * 8;
        sPt[j]  = $urandom_range(0, 3) == 0;
        sC[j]   = $urandom_range(0, 1);
        sD[j]   = $urandom_range(0, 3) != 0;
        sU[j]   = $urandom_range(0, 2) != 0;
      end
      step("mixed");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule